// File: doc/BRIEF.md
# Three-Level Translation Table Walker

This block resolves a translation-buffer miss by walking a three-tier table tree held in memory. A miss request brings a virtual address and an access kind. The walker starts from a root-frame register that is loaded when the address space changes. It then issues up to three word reads in sequence on a request/response memory port. Each fetched entry either points to the frame of the next table or, at the last tier, is the leaf mapping.

After a clean walk, the leaf entry goes to the translation buffer as a one-cycle fill so the access can be retried. If an entry at any tier is not valid, the walk stops without further reads. A one-cycle fault report then carries the virtual address, the access kind and the tier that failed. Only one walk is in flight at a time.

Top module: `xlat_walker`

## Requirements
- R1: While reset is high and in the first cycle after it, the walker is idle: miss_ready is 1 and mem_req_valid, fill_valid and fault_valid are 0.
- R2: The first read address is root_frame * 2^13 + va[42:33] * 8. The root frame used is the value held in the root register when the miss is accepted.
- R3: The tier-2 and tier-3 read addresses are frame * 2^13 + index * 8. The frame is bits [63:29] of the previous entry, and the index is va[32:23] for tier 2 and va[22:13] for tier 3.
- R4: An entry with bit 0 clear ends the walk at once, with no further read. fault_level reports the failing tier as 1, 2 or 3.
- R5: A fault raises fault_valid for exactly one cycle. fault_va and fault_acc then carry the accepted virtual address and access kind unchanged (0 load, 1 store, 2 fetch).
- R6: After a valid third entry, fill_valid is high for exactly one cycle with fill_entry equal to that entry and fill_va equal to the accepted address. The walker is idle in the next cycle.
- R7: miss_ready is 0 from the cycle after a miss is accepted until the walk ends. A miss offered during that time is not taken.
- R8: A read request stays asserted with a stable address until mem_req_ready is seen.
- R9: Exactly one read is issued per tier. A response that arrives while idle or before the request was accepted has no effect.
- R10: A root register load in the same cycle as a miss acceptance does not affect that walk. It applies to the next walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| root_we | input | 1 | load the root-frame register |
| root_frame | input | 35 | frame number of the tier-1 table |
| miss_valid | input | 1 | miss request offered |
| miss_ready | output | 1 | walker idle, miss accepted when valid |
| miss_va | input | 43 | virtual address of the miss |
| miss_acc | input | 2 | access kind: 0 load, 1 store, 2 fetch |
| mem_req_valid | output | 1 | read request |
| mem_req_ready | input | 1 | read request taken |
| mem_req_addr | output | 48 | byte address of the entry to read |
| mem_resp_valid | input | 1 | read data present |
| mem_resp_data | input | 64 | fetched entry |
| fill_valid | output | 1 | leaf entry delivered |
| fill_va | output | 43 | address that was walked |
| fill_entry | output | 64 | leaf entry |
| fault_valid | output | 1 | walk aborted on an invalid entry |
| fault_va | output | 43 | faulting virtual address |
| fault_acc | output | 2 | attempted access kind |
| fault_level | output | 2 | tier at which the walk failed (1..3) |

## Verification
The bench builds the walker with its default widths: 10-bit indices, a 13-bit offset, 48-bit physical addresses and 64-bit entries. With these widths the index values 0 and 1023 reach both edges of each table. The bench sweeps every abort tier, including none, against every access kind and three index patterns. Response latency, request stalls and stray responses vary across the sweep. A directed case then loads the root register on the accept edge.

// File: rtl/xw_pkg.sv
package xw_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_LV1   = 3'd1,
    S_LV2   = 3'd2,
    S_LV3   = 3'd3,
    S_FILL  = 3'd4,
    S_FAULT = 3'd5
  } walk_st_e;

  localparam logic [1:0] ACC_LOAD  = 2'd0;
  localparam logic [1:0] ACC_STORE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;
endpackage

// File: rtl/xw_idx_sel.sv
module xw_idx_sel #(
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 13,
  parameter int LEVELS = 3,
  parameter int LVL_W  = 2,
  localparam int VA_W  = LEVELS * IDX_W + OFF_W
) (
  input  logic [VA_W-1:0]  va,
  input  logic [LVL_W-1:0] lvl,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W-1:0] fld [LEVELS];

  // tier 0 takes the most significant index field
  for (genvar g = 0; g < LEVELS; g++) begin : g_fld
    assign fld[g] = va[OFF_W + (LEVELS - 1 - g) * IDX_W +: IDX_W];
  end

  always_comb begin
    idx = fld[0];
    for (int i = 1; i < LEVELS; i++) begin
      if (lvl == LVL_W'(i)) idx = fld[i];
    end
  end
endmodule

// File: rtl/xw_tbl_addr.sv
module xw_tbl_addr #(
  parameter int PA_W    = 48,
  parameter int OFF_W   = 13,
  parameter int IDX_W   = 10,
  parameter int ENT_LG  = 3,
  localparam int FRAME_W = PA_W - OFF_W
) (
  input  logic [FRAME_W-1:0] frame,
  input  logic [IDX_W-1:0]   idx,
  output logic [PA_W-1:0]    addr
);
  logic [PA_W-1:0] tbl_base;
  logic [PA_W-1:0] ent_off;

  assign tbl_base = {frame, {OFF_W{1'b0}}};
  assign ent_off  = PA_W'(idx) << ENT_LG;
  assign addr     = tbl_base + ent_off;
endmodule

// File: rtl/xw_ent_dec.sv
module xw_ent_dec #(
  parameter int ENTRY_W = 64,
  parameter int FRAME_W = 35
) (
  input  logic [ENTRY_W-1:0] ent,
  output logic               ok,
  output logic [FRAME_W-1:0] frame
);
  assign ok    = ent[0];
  assign frame = ent[ENTRY_W-1 -: FRAME_W];
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker #(
  parameter int IDX_W    = 10,
  parameter int OFF_W    = 13,
  parameter int PA_W     = 48,
  parameter int ENTRY_W  = 64,
  localparam int LEVELS  = 3,
  localparam int LVL_W   = 2,
  localparam int VA_W    = LEVELS * IDX_W + OFF_W,
  localparam int FRAME_W = PA_W - OFF_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               root_we,
  input  logic [FRAME_W-1:0] root_frame,
  input  logic               miss_valid,
  output logic               miss_ready,
  input  logic [VA_W-1:0]    miss_va,
  input  logic [1:0]         miss_acc,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [PA_W-1:0]    mem_req_addr,
  input  logic               mem_resp_valid,
  input  logic [ENTRY_W-1:0] mem_resp_data,
  output logic               fill_valid,
  output logic [VA_W-1:0]    fill_va,
  output logic [ENTRY_W-1:0] fill_entry,
  output logic               fault_valid,
  output logic [VA_W-1:0]    fault_va,
  output logic [1:0]         fault_acc,
  output logic [1:0]         fault_level
);
  import xw_pkg::*;

  walk_st_e           st_q;
  logic [FRAME_W-1:0] root_q;
  logic [VA_W-1:0]    va_q;
  logic [1:0]         acc_q;
  logic               req_v_q;
  logic [PA_W-1:0]    req_a_q;
  logic [ENTRY_W-1:0] leaf_q;
  logic [1:0]         flvl_q;

  logic [VA_W-1:0]    sel_va;
  logic [LVL_W-1:0]   sel_lvl;
  logic [IDX_W-1:0]   sel_idx;
  logic [FRAME_W-1:0] sel_frame;
  logic [PA_W-1:0]    nxt_addr;
  logic               ent_ok;
  logic [FRAME_W-1:0] ent_frame;
  logic               in_read;

  assign in_read = (st_q == S_LV1) || (st_q == S_LV2) || (st_q == S_LV3);

  // one shared index/address path: tier 1 from the root, later tiers from the fetched entry
  always_comb begin
    sel_va    = va_q;
    sel_lvl   = '0;
    sel_frame = ent_frame;
    unique case (st_q)
      S_IDLE: begin sel_va = miss_va; sel_lvl = LVL_W'(0); sel_frame = root_q; end
      S_LV1:  sel_lvl = LVL_W'(1);
      default: sel_lvl = LVL_W'(2);
    endcase
  end

  xw_idx_sel #(.IDX_W(IDX_W), .OFF_W(OFF_W), .LEVELS(LEVELS), .LVL_W(LVL_W)) u_idx (
    .va(sel_va), .lvl(sel_lvl), .idx(sel_idx)
  );

  xw_tbl_addr #(.PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .ENT_LG(3)) u_addr (
    .frame(sel_frame), .idx(sel_idx), .addr(nxt_addr)
  );

  xw_ent_dec #(.ENTRY_W(ENTRY_W), .FRAME_W(FRAME_W)) u_dec (
    .ent(mem_resp_data), .ok(ent_ok), .frame(ent_frame)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= S_IDLE;
      root_q  <= '0;
      va_q    <= '0;
      acc_q   <= '0;
      req_v_q <= 1'b0;
      req_a_q <= '0;
      leaf_q  <= '0;
      flvl_q  <= '0;
    end else begin
      if (root_we) root_q <= root_frame;
      unique case (st_q)
        S_IDLE: begin
          if (miss_valid) begin
            va_q    <= miss_va;
            acc_q   <= miss_acc;
            req_v_q <= 1'b1;
            req_a_q <= nxt_addr;
            st_q    <= S_LV1;
          end
        end
        S_LV1, S_LV2, S_LV3: begin
          if (req_v_q) begin
            if (mem_req_ready) req_v_q <= 1'b0;
          end else if (mem_resp_valid) begin
            if (!ent_ok) begin
              flvl_q <= (st_q == S_LV1) ? 2'd1 : (st_q == S_LV2) ? 2'd2 : 2'd3;
              st_q   <= S_FAULT;
            end else if (st_q == S_LV3) begin
              leaf_q <= mem_resp_data;
              st_q   <= S_FILL;
            end else begin
              req_v_q <= 1'b1;
              req_a_q <= nxt_addr;
              st_q    <= (st_q == S_LV1) ? S_LV2 : S_LV3;
            end
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign miss_ready    = (st_q == S_IDLE);
  assign mem_req_valid = req_v_q;
  assign mem_req_addr  = req_a_q;
  assign fill_valid    = (st_q == S_FILL);
  assign fill_va       = va_q;
  assign fill_entry    = leaf_q;
  assign fault_valid   = (st_q == S_FAULT);
  assign fault_va      = va_q;
  assign fault_acc     = acc_q;
  assign fault_level   = flvl_q;

  // R1: reset returns the walker to idle
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (miss_ready && !mem_req_valid && !fill_valid && !fault_valid));

  // R8: request held with a stable address until taken
  a_r8_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R7: an accepted miss makes the walker busy
  a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (miss_valid && miss_ready) |=> !miss_ready);

  // R6: fill is a single-cycle pulse followed by idle
  a_r6_fill_pulse: assert property (@(posedge clk) disable iff (rst)
    fill_valid |=> (!fill_valid && miss_ready));

  // R5: fault is a single-cycle pulse followed by idle
  a_r5_fault_pulse: assert property (@(posedge clk) disable iff (rst)
    fault_valid |=> (!fault_valid && miss_ready && !mem_req_valid));

  // R4: no read is outstanding while a fault is reported
  a_r4_no_read_on_fault: assert property (@(posedge clk) disable iff (rst)
    fault_valid |-> (!mem_req_valid && !fill_valid));

  // R9: a taken request is not reissued until a response has moved the walk on
  a_r9_single_read: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

  // R4: fault reports a tier between 1 and 3
  a_r4_level_range: assert property (@(posedge clk) disable iff (rst)
    fault_valid |-> (fault_level != 2'd0));
endmodule

// File: tb/test_xlat_walker.sv
module test_xlat_walker;
  localparam int IDX_W = 10, OFF_W = 13, PA_W = 48, EW = 64;
  localparam int VA_W = 3 * IDX_W + OFF_W;
  localparam int FW = PA_W - OFF_W;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, root_we, miss_valid, mem_req_ready, mem_resp_valid;
  logic [FW-1:0] root_frame;
  logic [VA_W-1:0] miss_va;
  logic [1:0] miss_acc;
  logic [EW-1:0] mem_resp_data;
  logic miss_ready, mem_req_valid, fill_valid, fault_valid;
  logic [PA_W-1:0] mem_req_addr;
  logic [VA_W-1:0] fill_va, fault_va;
  logic [EW-1:0] fill_entry;
  logic [1:0] fault_acc, fault_level;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  xlat_walker i_xlat_walker (
    .clk(clk), .rst(rst), .root_we(root_we), .root_frame(root_frame),
    .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_va(miss_va), .miss_acc(miss_acc),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data),
    .fill_valid(fill_valid), .fill_va(fill_va), .fill_entry(fill_entry),
    .fault_valid(fault_valid), .fault_va(fault_va), .fault_acc(fault_acc), .fault_level(fault_level)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] mkframe(input int k, input int l);
    logic [63:0] v;
    v = 64'h5A5A_1234_9 * 64'(k + 1) + 64'(l) * 64'h3_0001_7 + 64'(l) << 33;
    return v[FW-1:0];
  endfunction

  function automatic logic [EW-1:0] mkent(input logic [FW-1:0] fr, input int k, input bit v);
    logic [27:0] junk;
    junk = 28'hA5C3F0E ^ 28'(k * 7919);
    return {fr, junk, v};
  endfunction

  function automatic logic [PA_W-1:0] expaddr(input logic [FW-1:0] fr, input logic [IDX_W-1:0] ix);
    return (PA_W'(fr) << OFF_W) + (PA_W'(ix) << 3);
  endfunction

  task automatic load_root(input logic [FW-1:0] fr);
    root_we = 1'b1; root_frame = fr;
    @(negedge clk);
    root_we = 1'b0;
  endtask

  // drives one walk; fl = tier whose entry is invalid (0 = none)
  task automatic do_walk(input logic [VA_W-1:0] va, input logic [1:0] acc, input int fl,
                         input int lat, input int stall, input bit stray, input int k,
                         input logic [FW-1:0] rootf, input bit rebase, input logic [FW-1:0] newroot);
    logic [FW-1:0] fr;
    logic [IDX_W-1:0] ix;
    logic [EW-1:0] ent;
    logic [PA_W-1:0] held;
    miss_valid = 1'b1; miss_va = va; miss_acc = acc;
    if (rebase) begin root_we = 1'b1; root_frame = newroot; end
    @(negedge clk);
    miss_valid = 1'b0; root_we = 1'b0;
    fr = rootf;
    for (int l = 1; l <= 3; l++) begin
      int n = 0;
      while (!mem_req_valid && n < 20) begin @(negedge clk); n++; end
      ix = va[OFF_W + (3 - l) * IDX_W +: IDX_W];
      if (l == 1) chk(mem_req_addr == expaddr(fr, ix), "R2", "tier-1 address", 64'(mem_req_addr), 64'(expaddr(fr, ix)));
      else chk(mem_req_addr == expaddr(fr, ix), "R3", "lower-tier address", 64'(mem_req_addr), 64'(expaddr(fr, ix)));
      if (l == 1) chk(miss_ready == 1'b0, "R7", "busy during walk", 64'(miss_ready), 64'd0);
      held = mem_req_addr;
      for (int s = 0; s < stall; s++) begin
        if (s == 0) begin miss_valid = 1'b1; miss_va = ~va; end
        if (stray) begin mem_resp_valid = 1'b1; mem_resp_data = '0; end
        @(negedge clk);
        miss_valid = 1'b0; mem_resp_valid = 1'b0;
        chk(mem_req_valid && mem_req_addr == held, "R8", "request held", 64'(mem_req_addr), 64'(held));
      end
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      chk(mem_req_valid == 1'b0, "R9", "one read per tier", 64'(mem_req_valid), 64'd0);
      repeat (lat) @(negedge clk);
      fr = mkframe(k, l);
      ent = mkent(fr, k + l, (l != fl));
      mem_resp_valid = 1'b1; mem_resp_data = ent;
      @(negedge clk);
      mem_resp_valid = 1'b0;
      if (l == fl) begin
        chk(fault_valid == 1'b1, "R4", "fault raised", 64'(fault_valid), 64'd1);
        chk(fault_level == 2'(l), "R4", "fault tier", 64'(fault_level), 64'(l));
        chk(mem_req_valid == 1'b0 && fill_valid == 1'b0, "R4", "no read or fill after fault",
            64'({mem_req_valid, fill_valid}), 64'd0);
        chk(fault_va == va, "R5", "fault address", 64'(fault_va), 64'(va));
        chk(fault_acc == acc, "R5", "fault access kind", 64'(fault_acc), 64'(acc));
        @(negedge clk);
        chk(fault_valid == 1'b0 && miss_ready == 1'b1, "R5", "fault single cycle",
            64'({fault_valid, miss_ready}), 64'b01);
        return;
      end
      if (l == 3) begin
        chk(fill_valid == 1'b1 && fault_valid == 1'b0, "R6", "fill raised", 64'({fill_valid, fault_valid}), 64'b10);
        chk(fill_entry == ent, "R6", "fill entry", fill_entry, ent);
        chk(fill_va == va, "R6", "fill address", 64'(fill_va), 64'(va));
        @(negedge clk);
        chk(fill_valid == 1'b0 && miss_ready == 1'b1, "R6", "fill single cycle",
            64'({fill_valid, miss_ready}), 64'b01);
        chk(mem_req_valid == 1'b0, "R7", "no walk started by busy-time miss", 64'(mem_req_valid), 64'd0);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R6 watchdog: actual hung expected finished");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; root_we = 1'b0; root_frame = '0; miss_valid = 1'b0; miss_va = '0; miss_acc = '0;
    mem_req_ready = 1'b0; mem_resp_valid = 1'b0; mem_resp_data = '0;
    repeat (3) @(negedge clk);
    chk(miss_ready && !mem_req_valid && !fill_valid && !fault_valid, "R1", "idle in reset",
        64'({miss_ready, mem_req_valid, fill_valid, fault_valid}), 64'b1000);
    rst = 1'b0;
    @(negedge clk);
    chk(miss_ready && !mem_req_valid && !fill_valid && !fault_valid, "R1", "idle after reset",
        64'({miss_ready, mem_req_valid, fill_valid, fault_valid}), 64'b1000);

    // R9: stray response while idle
    mem_resp_valid = 1'b1; mem_resp_data = '0;
    @(negedge clk);
    mem_resp_valid = 1'b0;
    chk(!fault_valid && !fill_valid && !mem_req_valid && miss_ready, "R9", "idle stray response",
        64'({fault_valid, fill_valid, mem_req_valid, miss_ready}), 64'b0001);

    for (int fl = 0; fl < 4; fl++) begin
      for (int acc = 0; acc < 3; acc++) begin
        for (int pat = 0; pat < 3; pat++) begin
          int k = fl * 9 + acc * 3 + pat;
          logic [IDX_W-1:0] a, b, c;
          logic [VA_W-1:0] va;
          logic [FW-1:0] rf;
          if (pat == 0) begin a = '0; b = '0; c = '0; end
          else if (pat == 1) begin a = '1; b = '1; c = '1; end
          else begin a = IDX_W'(k * 37 + 5); b = IDX_W'(k * 301 + 700); c = IDX_W'(k * 13 + 512); end
          va = {a, b, c, OFF_W'(k * 91 + 3)};
          rf = mkframe(k, 0);
          load_root(rf);
          do_walk(va, 2'(acc), fl, (fl + acc + pat) % 3, pat, (pat == 2), k, rf, 1'b0, '0);
        end
      end
    end

    // R10: root loaded on the accept edge applies only to the next walk
    begin
      logic [FW-1:0] r1, r2;
      logic [VA_W-1:0] va;
      r1 = mkframe(90, 0); r2 = mkframe(91, 0);
      va = {10'd1, 10'd1022, 10'd513, 13'h1ABC};
      load_root(r1);
      do_walk(va, 2'd1, 0, 1, 1, 1'b0, 90, r1, 1'b1, r2);
      do_walk(va, 2'd2, 0, 0, 0, 1'b0, 91, r2, 1'b0, '0);
      chk(1'b1, "R10", "root switch sequence completed", 64'd0, 64'd0);
    end

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule